// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that gives a controller on a two-wire bus byte-wide access to a small bank of 8-bit registers. It watches the synchronized clock and data lines, recognises start, repeated start and stop conditions, matches a 7-bit device address, and answers on the data line only through an open-drain pull-low enable. It never drives the line high.

A write transaction names a register after the device address. The byte that names the register is acknowledged only when that register exists. Data bytes then land in consecutive registers, because the pointer advances after every byte that is stored. A read transaction sets the pointer in the same way, follows it with a repeated start and the address with the read bit, and receives one byte from the pointed register. Every stored byte also appears for one cycle on a write-event port, so that neighbouring logic can follow register updates.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the data-line pull-low output is 0 and the write-event strobe is 0.
- R2: The first byte after a start carries the 7-bit device address in bits 7..1 (shifted most significant bit first) and the direction in bit 0, where 0 is write and 1 is read. The target pulls SDA low in the ninth clock only when bits 7..1 equal DEV_ADDR. On a mismatch it leaves SDA released and ignores every byte until the next start or stop.
- R3: In a write, the byte after the device address is a register number. It is acknowledged and loaded into the pointer only when it is below NUM_REGS. Otherwise it gets no acknowledge, and the following bytes get no acknowledge and cause no write.
- R4: Each later write byte is stored at the pointer and acknowledged, and the pointer then increments by one. Each stored byte produces one single-cycle pulse on regWrEn, with regWrAddr equal to the register number and regWrData equal to the byte.
- R5: Once the pointer has advanced past register NUM_REGS-1, further write bytes in the burst are not acknowledged and are not stored.
- R6: After a repeated start and an acknowledged address with the read bit, the target shifts out the register at the pointer, most significant bit first. The pointer is kept across repeated start and stop. A pointer past the last register reads as 8'hFF.
- R7: After one read byte the target keeps SDA released until the next start or stop, whatever the controller answers in the ninth clock.
- R8: The pull-low output changes only while SCL is low.
- R9: A stop returns the target to idle from any point. A start, including one in the middle of a byte, restarts the address phase and keeps the pointer. An unfinished byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sdaPullLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| regWrEn | output | 1 | One-cycle pulse when a register is written |
| regWrAddr | output | 8 | Register number of the write |
| regWrData | output | 8 | Byte written |

## Verification
Each SCL or SDA transition passes two synchronizer flops and one edge-detect flop, so the target acts on it three clock edges later. The acknowledge drive, the write-event pulse and each read-data bit therefore appear on the third rising clock edge after the SCL falling edge that triggers them. The bench keeps SCL low for eight clocks before changing it again. It samples the acknowledge and read bits in the middle of the SCL high phase, well after those three edges. The reference model queues each expected register write before the byte is sent and compares it against the write-event port on every clock. The model tracks the pointer across stops and repeated starts, and the bench compares every read byte with that model.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shiftIn;
    logic ackOn;
    logic ackOff;
    logic loadPtr;
    logic incPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic txOff;
  } strobe_t;

endpackage

// File: rtl/i2ct_linesync.sv
module i2ct_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen,
  output logic sdaBit
);

  logic [STAGES-1:0] sclSh;
  logic [STAGES-1:0] sdaSh;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclSh[STAGES-1];
  assign sdaNow    = sdaSh[STAGES-1];
  assign sdaBit    = sdaNow;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

endmodule

// File: rtl/i2ct_datapath.sv
module i2ct_datapath
  import i2ct_pkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic       sdaBit,
  output logic [3:0] bitCnt,
  output logic       addrMatch,
  output logic       rwBit,
  output logic       regValid,
  output logic       ptrValid,
  output logic       sdaPullLow,
  output logic       regWrEn,
  output logic [7:0] regWrAddr,
  output logic [7:0] regWrData
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0]       rxByte;
  logic [7:0]       txShift;
  logic [PTR_W-1:0] ptr;
  logic [IDX_W-1:0] idx;
  logic             ackDrive;
  logic             txActive;
  logic [7:0]       regs [NUM_REGS];

  assign idx = IDX_W'(ptr);

  // bit counter: 0..8 data bits, 9 after the acknowledge clock
  always_ff @(posedge clk) begin
    if (!rstN)           bitCnt <= '0;
    else if (stb.cntClr) bitCnt <= '0;
    else if (stb.cntInc) bitCnt <= bitCnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rxByte <= '0;
    else if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ptr <= '0;
    else if (stb.loadPtr) ptr <= PTR_W'(rxByte);
    else if (stb.incPtr)  ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ackDrive <= 1'b0;
    else if (stb.ackOff) ackDrive <= 1'b0;
    else if (stb.ackOn)  ackDrive <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txShift  <= 8'hFF;
    end else if (stb.txOff) begin
      txActive <= 1'b0;
    end else if (stb.loadTx) begin
      txActive <= 1'b1;
      txShift  <= ptrValid ? regs[idx] : 8'hFF;
    end else if (stb.shiftTx) begin
      txShift  <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= stb.writeReg;
      if (stb.writeReg) begin
        regWrAddr <= 8'(ptr);
        regWrData <= rxByte;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                                  regs[g] <= '0;
      else if (stb.writeReg && idx == IDX_W'(g)) regs[g] <= rxByte;
    end
  end

  assign addrMatch  = (rxByte[7:1] == DEV_ADDR);
  assign rwBit      = rxByte[0];
  assign regValid   = (int'(rxByte) < NUM_REGS);
  assign ptrValid   = (int'(ptr) < NUM_REGS);
  assign sdaPullLow = ackDrive | (txActive & ~txShift[7]);

endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [3:0] bitCnt,
  input  logic       addrMatch,
  input  logic       rwBit,
  input  logic       regValid,
  input  logic       ptrValid,
  output strobe_t    stb
);

  phase_e phase;
  phase_e phaseNext;
  logic   busy;

  assign busy = (phase != PH_IDLE) && (phase != PH_SKIP);

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    if (stopSeen) begin
      phaseNext  = PH_IDLE;
      stb.ackOff = 1'b1;
      stb.txOff  = 1'b1;
      stb.cntClr = 1'b1;
    end else if (startSeen) begin
      phaseNext  = PH_DEV;
      stb.ackOff = 1'b1;
      stb.txOff  = 1'b1;
      stb.cntClr = 1'b1;
    end else if (busy) begin
      if (sclRise && bitCnt != 4'd9) begin
        stb.cntInc  = 1'b1;
        stb.shiftIn = (bitCnt < 4'd8);
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          // byte complete: decide the acknowledge for the ninth clock
          case (phase)
            PH_DEV: begin
              if (addrMatch) stb.ackOn = 1'b1;
              else           phaseNext = PH_SKIP;
            end
            PH_REG: begin
              if (regValid) begin
                stb.ackOn   = 1'b1;
                stb.loadPtr = 1'b1;
              end else begin
                phaseNext = PH_SKIP;
              end
            end
            PH_WDATA: begin
              if (ptrValid) begin
                stb.ackOn    = 1'b1;
                stb.writeReg = 1'b1;
                stb.incPtr   = 1'b1;
              end
            end
            PH_RDATA: stb.txOff = 1'b1;
            default: ;
          endcase
        end else if (bitCnt == 4'd9) begin
          // end of the acknowledge clock
          stb.ackOff = 1'b1;
          stb.cntClr = 1'b1;
          case (phase)
            PH_DEV: begin
              if (rwBit) begin
                phaseNext  = PH_RDATA;
                stb.loadTx = 1'b1;
              end else begin
                phaseNext = PH_REG;
              end
            end
            PH_REG:   phaseNext = PH_WDATA;
            PH_RDATA: phaseNext = PH_SKIP;
            default: ;
          endcase
        end else if (phase == PH_RDATA && bitCnt != 4'd0) begin
          stb.shiftTx = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic       regWrEn,
  output logic [7:0] regWrAddr,
  output logic [7:0] regWrData
);

  import i2ct_pkg::*;

  strobe_t    stb;
  logic       sclRise;
  logic       sclFall;
  logic       startSeen;
  logic       stopSeen;
  logic       sdaBit;
  logic [3:0] bitCnt;
  logic       addrMatch;
  logic       rwBit;
  logic       regValid;
  logic       ptrValid;

  i2ct_linesync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .sdaBit    (sdaBit)
  );

  i2ct_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .bitCnt    (bitCnt),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .regValid  (regValid),
    .ptrValid  (ptrValid),
    .stb       (stb)
  );

  i2ct_datapath #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .sdaBit     (sdaBit),
    .bitCnt     (bitCnt),
    .addrMatch  (addrMatch),
    .rwBit      (rwBit),
    .regValid   (regValid),
    .ptrValid   (ptrValid),
    .sdaPullLow (sdaPullLow),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int NUM_REGS = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaPullLow,
  input logic       regWrEn,
  input logic [7:0] regWrAddr
);

  // R3 R5
  wr_addr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (int'(regWrAddr) < NUM_REGS));

  // R4
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R4
  wr_is_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> sdaPullLow);

  // R8
  pull_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

  // R8
  pull_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn);

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NUM_REGS(NUM_REGS)) chk_i (.*);

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 8;
  localparam int NREG       = 16;
  localparam logic [6:0] DEV = 7'h2A;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaBus;
  logic       sdaPullLow;
  logic       regWrEn;
  logic [7:0] regWrAddr;
  logic [7:0] regWrData;

  int tests = 0;
  int fails = 0;
  int r8Viol = 0;
  bit done = 0;
  logic pullPrev = 1'b0;

  int expReg [NREG];
  int expPtr = 0;
  int expA [$];
  int expD [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullLow;

  i2c_reg_target #(.NUM_REGS(NREG), .DEV_ADDR(DEV)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .sdaPullLow (sdaPullLow),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model: every write-event pulse must match the queued expectation (R4)
  always @(negedge clk) begin
    if (rstN) begin
      if (sclM && sdaPullLow != pullPrev) r8Viol++;
      pullPrev = sdaPullLow;
      if (regWrEn) begin
        if (expA.size() == 0) begin
          check(1'b0, "R4 unexpected write", regWrAddr, 0);
        end else begin
          check(regWrAddr == expA[0] && regWrData == expD[0], "R4 write event",
                {regWrAddr, regWrData}, (expA[0] << 8) | expD[0]);
          void'(expA.pop_front());
          void'(expD.pop_front());
        end
      end
    end
  end

  task automatic startCond();
    sdaM = 1'b1; tick(HP);
    sclM = 1'b1; tick(HP);
    sdaM = 1'b0; tick(HP);
    sclM = 1'b0; tick(HP);
  endtask

  task automatic stopCond();
    tick(2); sdaM = 1'b0; tick(HP);
    sclM = 1'b1; tick(HP);
    sdaM = 1'b1; tick(HP);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(2); sdaM = b[i]; tick(HP - 2);
      sclM = 1'b1; tick(HP);
      sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    tick(2); sdaM = 1'b1; tick(HP - 2);
    sclM = 1'b1; tick(HP/2);
    ack = (sdaBus == 1'b0);
    tick(HP/2);
    sclM = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] b, input logic masterAck);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP); sclM = 1'b1; tick(HP/2);
      b[i] = sdaBus;
      tick(HP/2); sclM = 1'b0;
    end
    tick(2); sdaM = !masterAck; tick(HP - 2);
    sclM = 1'b1; tick(HP);
    sclM = 1'b0; tick(2);
    sdaM = 1'b1;
  endtask

  function automatic int expRead();
    return (expPtr < NREG) ? expReg[expPtr] : 8'hFF;
  endfunction

  task automatic wrBurst(input int ra, input int n, input int base);
    logic ack;
    bit valid;
    startCond();
    sendByte({DEV, 1'b0}, ack);
    check(ack, "R2 write address ack", ack, 1);
    valid = (ra < NREG);
    sendByte(8'(ra), ack);
    check(ack == valid, "R3 register number ack", ack, valid);
    if (valid) expPtr = ra;
    for (int i = 0; i < n; i++) begin
      int d;
      bit will;
      d = (base + 37 * i) & 8'hFF;
      will = valid && (expPtr < NREG);
      if (will) begin
        expA.push_back(expPtr);
        expD.push_back(d);
        expReg[expPtr] = d;
        expPtr++;
      end
      sendByte(8'(d), ack);
      if (!valid)         check(ack == 1'b0, "R3 byte after bad register", ack, 0);
      else if (will)      check(ack == 1'b1, "R4 data byte ack", ack, 1);
      else                check(ack == 1'b0, "R5 byte past last register", ack, 0);
    end
    stopCond();
  endtask

  task automatic readTail(input string req);
    logic ack;
    logic [7:0] b;
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R6 read address ack", ack, 1);
    readByte(b, 1'b0);
    check(b == 8'(expRead()), req, b, expRead());
    tick(4);
    check(sdaPullLow == 1'b0, "R7 released after read", sdaPullLow, 0);
    stopCond();
  endtask

  task automatic rdReg(input int ra, input string req);
    logic ack;
    startCond();
    sendByte({DEV, 1'b0}, ack);
    check(ack, "R2 write address ack", ack, 1);
    sendByte(8'(ra), ack);
    check(ack == 1'b1, "R3 valid register ack", ack, 1);
    expPtr = ra;
    startCond();
    readTail(req);
  endtask

  task automatic rdCur(input string req);
    startCond();
    readTail(req);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) expReg[i] = 0;
    tick(5);
    rstN = 1'b1;
    tick(3);
    // R1
    check(sdaPullLow == 1'b0, "R1 reset pull-low", sdaPullLow, 0);
    check(regWrEn == 1'b0, "R1 reset write strobe", regWrEn, 0);

    // R2 R4: burst write of four bytes starting at register 3
    wrBurst(3, 4, 8'h5C);
    // R6: read back through repeated start
    rdReg(3, "R6 read register 3");
    rdReg(6, "R6 read register 6");
    rdCur("R6 pointer kept across stop");

    // R2: wrong device address, following bytes ignored
    startCond();
    sendByte({7'h2B, 1'b0}, ack);
    check(ack == 1'b0, "R2 mismatched address nak", ack, 0);
    sendByte(8'h05, ack);
    check(ack == 1'b0, "R2 ignored after mismatch", ack, 0);
    sendByte(8'h99, ack);
    check(ack == 1'b0, "R2 ignored after mismatch", ack, 0);
    stopCond();
    rdCur("R2 pointer untouched by ignored bytes");

    // R3: register number out of range
    wrBurst(8'h20, 2, 8'h11);
    rdCur("R3 pointer untouched by bad register");

    // R5: burst running off the end
    wrBurst(14, 3, 8'hA3);
    rdCur("R5 past-end pointer reads FF");
    rdReg(15, "R5 last register holds its byte");
    rdReg(14, "R5 second-last register");

    // R7: controller acknowledges, target still releases
    startCond();
    sendByte({DEV, 1'b1}, ack);
    check(ack, "R7 read address ack", ack, 1);
    readByte(b, 1'b1);
    check(b == 8'(expRead()), "R7 first byte", b, expRead());
    readByte(b, 1'b0);
    check(b == 8'hFF, "R7 no second byte driven", b, 8'hFF);
    stopCond();

    // R9: stop in the middle of a byte
    startCond();
    sendByte({DEV, 1'b0}, ack);
    check(ack, "R9 address ack", ack, 1);
    sendBits(8'h01, 3);
    stopCond();
    rdCur("R9 stop mid-byte keeps pointer");

    // R9: repeated start in the middle of a data byte
    startCond();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'h02, ack);
    check(ack, "R9 register number ack", ack, 1);
    expPtr = 2;
    sendBits(8'hF0, 4);
    startCond();
    readTail("R9 partial byte not written");

    tick(20);
    check(expA.size() == 0, "R4 all expected writes seen", expA.size(), 0);
    check(r8Viol == 0, "R8 pull-low stable while SCL high", r8Viol, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule